// File: doc/BRIEF.md
# Compare-and-skip execution unit

This block is the execution slice of a small 8-bit accumulator processor that handles the two conditional-skip compares. Each compares one data-memory byte with the working register as unsigned numbers. The "greater" form skips when the memory byte is above the working register. The "less" form skips when the memory byte is below it. Each instruction cycle lasts four clocks, called phases Q1 to Q4. In Q1 the slice takes the word that the fetch stage presents at the current program counter. In Q2 it reads the addressed data byte. In Q3 it compares. Q4 writes nothing back.

A taken skip squashes the word that has already been fetched. If that word opens a two-word instruction, its second word is squashed as well. A squashed slot still takes a full cycle and still advances the program counter, but it does nothing else. The data address is 12 bits wide. It comes either from the bank register with the 8-bit offset appended, or from the access bank, chosen by one bit of the instruction. No status flag is produced. Words that are not compares, and that are not in a squashed slot, pass through as one-cycle no-ops.

Top module: `cmpskip_unit`

## Requirements
- R1: A word whose bits [15:9] are 0110010 compares the addressed byte with `wreg` as unsigned numbers and raises `skip_taken` in Q4 when the byte is strictly greater.
- R2: A word whose bits [15:9] are 0110000 raises `skip_taken` in Q4 when the addressed byte is strictly less than `wreg`, again unsigned.
- R3: When the byte equals `wreg`, neither compare form skips.
- R4: With instruction bit 8 set to 1, `dmem_addr` is `{bank_sel, word[7:0]}` during Q2.
- R5: With bit 8 set to 0, `bank_sel` is ignored. Offsets 0x00–0x7F address 0x000–0x07F, and offsets 0x80–0xFF address 0xF80–0xFFF.
- R6: `phase` is one-hot, with bit 0 for Q1 through bit 3 for Q4. It steps Q1→Q2→Q3→Q4→Q1 once per clock and sits at Q1 after reset.
- R7: `dmem_rd` is high only in Q2 of a compare slot that is not squashed.
- R8: `pc` advances by exactly one at the end of every Q4, whether the slot was executed, passed through or squashed, and holds in every other phase.
- R9: After a taken skip, the next slot is squashed: `slot_squashed` is high in its Q2–Q4. If that word is a one-word instruction, the slot after it executes normally, so the skip costs two cycles in total.
- R10: If the squashed word opens a two-word instruction, the following slot is squashed as well, for three cycles in total. A word opens a two-word instruction when bits [15:12] are 1100, or when bits [15:10] are 111011 (opcodes 0xEC–0xEF).
- R11: After reset, `pc` is 0 and `phase` is Q1, and `dmem_rd`, `slot_squashed` and `skip_taken` are all low.
- R12: A compare word that lands in a squashed slot neither reads memory nor skips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each phase lasts one clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_word | input | 16 | Program word at `pc`, presented by the fetch stage |
| wreg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank register, supplies the upper address bits |
| dmem_rdata | input | 8 | Data byte at `dmem_addr` |
| pc | output | 12 | Program counter, in words |
| phase | output | 4 | One-hot phase of the current instruction cycle |
| dmem_addr | output | 12 | Data memory address of the current slot |
| dmem_rd | output | 1 | Read strobe for the data memory |
| slot_squashed | output | 1 | Current slot is a squashed cycle (valid Q2–Q4) |
| skip_taken | output | 1 | Compare held in this slot (valid Q4) |

## Verification
The squash of a fetched word and the decode of that same word can fall in the same slot. The sharpest form is a skip followed directly by another compare that would itself skip if it ran. The bench sets this up and expects the second compare to produce no read strobe and no skip. It then expects the third word to execute normally and to start a fresh squash of its own. A further random program mixes compares, two-word openers and no-ops, and judges each slot's squash flag and skip flag against a bench-side model of the squash state.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;

    localparam int WORD_W = 16;
    localparam int OFS_W  = 8;

    // Upper seven bits of the two compare opcodes
    localparam logic [6:0] OPC_ABOVE = 7'b0110010;
    localparam logic [6:0] OPC_BELOW = 7'b0110000;

    // First-word patterns of the two-word instructions
    localparam logic [3:0] OPC_PAIR_MOVE = 4'b1100;
    localparam logic [5:0] OPC_PAIR_LONG = 6'b111011;

    typedef enum logic [1:0] {
        K_PASS,
        K_ABOVE,
        K_BELOW,
        K_DEAD
    } slot_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HEAD,
        SQ_TAIL
    } squash_e;

endpackage

// File: rtl/cmpskip_decode.sv
module cmpskip_decode
    import cmpskip_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output slot_kind_e        kind,
    output logic              pair_head,
    output logic              use_bank,
    output logic [OFS_W-1:0]  offset
);

    always_comb begin
        if (word[15:9] == OPC_ABOVE) begin
            kind = K_ABOVE;
        end else if (word[15:9] == OPC_BELOW) begin
            kind = K_BELOW;
        end else begin
            kind = K_PASS;
        end
        pair_head = (word[15:12] == OPC_PAIR_MOVE) || (word[15:10] == OPC_PAIR_LONG);
        use_bank  = word[8];
        offset    = word[OFS_W-1:0];
    end

endmodule

// File: rtl/cmpskip_bank_addr.sv
module cmpskip_bank_addr #(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 8
) (
    input  logic [OFS_W-1:0]        offset,
    input  logic                    use_bank,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+OFS_W-1:0] addr
);

    // Access bank: low half of offsets maps to the bottom of memory,
    // high half maps to the top, i.e. the upper bits copy offset MSB.
    always_comb begin
        if (use_bank) begin
            addr = {bank, offset};
        end else begin
            addr = {{BANK_W{offset[OFS_W-1]}}, offset};
        end
    end

endmodule

// File: rtl/cmpskip_compare.sv
module cmpskip_compare #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] acc_val,
    output logic              above,
    output logic              below
);

    logic [DATA_W:0] diff;
    logic            borrow;
    logic            zero;

    // Unsigned subtraction of the accumulator from the memory byte
    always_comb begin
        diff   = {1'b0, mem_val} - {1'b0, acc_val};
        borrow = diff[DATA_W];
        zero   = (diff[DATA_W-1:0] == '0);
        above  = !borrow && !zero;
        below  = borrow;
    end

endmodule

// File: rtl/cmpskip_unit.sv
module cmpskip_unit
    import cmpskip_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       fetch_word,
    input  logic [DATA_W-1:0]       wreg,
    input  logic [BANK_W-1:0]       bank_sel,
    input  logic [DATA_W-1:0]       dmem_rdata,
    output logic [PC_W-1:0]         pc,
    output logic [3:0]              phase,
    output logic [BANK_W+OFS_W-1:0] dmem_addr,
    output logic                    dmem_rd,
    output logic                    slot_squashed,
    output logic                    skip_taken
);

    localparam int             ADDR_W = BANK_W + OFS_W;
    localparam int             N_PH   = 4;
    localparam int             PH_W   = $clog2(N_PH);
    localparam logic [PH_W-1:0] PH_Q1 = PH_W'(0);
    localparam logic [PH_W-1:0] PH_Q2 = PH_W'(1);
    localparam logic [PH_W-1:0] PH_Q3 = PH_W'(2);
    localparam logic [PH_W-1:0] PH_Q4 = PH_W'(3);
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic [PC_W-1:0]   pc;
        slot_kind_e        kind;
        squash_e           sq;
        logic              use_bank;
        logic [OFS_W-1:0]  offset;
        logic [DATA_W-1:0] opnd;
        logic              skip;
    } state_t;

    localparam state_t ST_RESET = '{
        ph:       PH_Q1,
        pc:       '0,
        kind:     K_PASS,
        sq:       SQ_IDLE,
        use_bank: 1'b0,
        offset:   '0,
        opnd:     '0,
        skip:     1'b0
    };

    state_t s_q;
    state_t s_d;

    slot_kind_e       dec_kind_d;
    logic             dec_pair_d;
    logic             dec_bank_d;
    logic [OFS_W-1:0] dec_ofs_d;
    logic [ADDR_W-1:0] addr_d;
    logic             cmp_above_d;
    logic             cmp_below_d;
    logic             is_cmp_d;

    cmpskip_decode u_dec (
        .word      (fetch_word),
        .kind      (dec_kind_d),
        .pair_head (dec_pair_d),
        .use_bank  (dec_bank_d),
        .offset    (dec_ofs_d)
    );

    cmpskip_bank_addr #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W)
    ) u_addr (
        .offset   (s_q.offset),
        .use_bank (s_q.use_bank),
        .bank     (bank_sel),
        .addr     (addr_d)
    );

    cmpskip_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .mem_val (s_q.opnd),
        .acc_val (wreg),
        .above   (cmp_above_d),
        .below   (cmp_below_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ph   = s_q.ph + PH_ONE;
        is_cmp_d = (s_q.kind == K_ABOVE) || (s_q.kind == K_BELOW);

        case (s_q.ph)
            PH_Q1: begin
                // Decode, or throw the fetched word away
                s_d.use_bank = dec_bank_d;
                s_d.offset   = dec_ofs_d;
                case (s_q.sq)
                    SQ_HEAD: begin
                        s_d.kind = K_DEAD;
                        s_d.sq   = dec_pair_d ? SQ_TAIL : SQ_IDLE;
                    end
                    SQ_TAIL: begin
                        s_d.kind = K_DEAD;
                        s_d.sq   = SQ_IDLE;
                    end
                    default: begin
                        s_d.kind = dec_kind_d;
                        s_d.sq   = SQ_IDLE;
                    end
                endcase
            end
            PH_Q2: begin
                if (is_cmp_d) begin
                    s_d.opnd = dmem_rdata;
                end
            end
            PH_Q3: begin
                s_d.skip = ((s_q.kind == K_ABOVE) && cmp_above_d) ||
                           ((s_q.kind == K_BELOW) && cmp_below_d);
            end
            default: begin
                s_d.pc   = s_q.pc + PC_ONE;
                s_d.skip = 1'b0;
                if (s_q.skip) begin
                    s_d.sq = SQ_HEAD;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        phase        = '0;
        phase[s_q.ph] = 1'b1;
    end

    assign pc            = s_q.pc;
    assign dmem_addr     = addr_d;
    assign dmem_rd       = (s_q.ph == PH_Q2) && is_cmp_d;
    assign slot_squashed = (s_q.kind == K_DEAD);
    assign skip_taken    = s_q.skip && (s_q.ph == PH_Q4);

endmodule

// File: rtl/cmpskip_checker.sv
module cmpskip_checker #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc,
    input logic [3:0]      phase,
    input logic            dmem_rd,
    input logic            slot_squashed,
    input logic            skip_taken
);

    localparam logic [PC_W-1:0] PC_INC = PC_W'(1);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1) else $error("phase not one-hot"); // R6

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> phase[0]) else $error("Q4 not followed by Q1"); // R6

    AST_READ_IN_Q2: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |-> phase[1]) else $error("read outside Q2"); // R7

    AST_READ_NOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |-> !slot_squashed) else $error("read in squashed slot"); // R12

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> (pc - $past(pc)) == PC_INC) else $error("pc did not step"); // R8

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[3] |=> $stable(pc)) else $error("pc moved mid-cycle"); // R8

    AST_SKIP_IN_Q4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_taken |-> (phase[3] && !slot_squashed)) else $error("skip misplaced"); // R9

    AST_SKIP_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
        skip_taken |-> ##2 slot_squashed) else $error("skip without squash"); // R9

endmodule

bind cmpskip_unit cmpskip_checker #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc            (pc),
    .phase         (phase),
    .dmem_rd       (dmem_rd),
    .slot_squashed (slot_squashed),
    .skip_taken    (skip_taken)
);

// File: tb/sim_cmpskip_unit.sv
module sim_cmpskip_unit;

    localparam int PC_W   = 12;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;
    localparam logic [7:0] SALT = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_word;
    logic [7:0]  wreg = '0;
    logic [3:0]  bank_sel = '0;
    logic [7:0]  dmem_rdata;
    logic [11:0] pc;
    logic [3:0]  phase;
    logic [11:0] dmem_addr;
    logic        dmem_rd;
    logic        slot_squashed;
    logic        skip_taken;

    logic [15:0] rom [0:31];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    cmpskip_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .wreg(wreg),
        .bank_sel(bank_sel), .dmem_rdata(dmem_rdata), .pc(pc), .phase(phase),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd),
        .slot_squashed(slot_squashed), .skip_taken(skip_taken)
    );

    // Bench-side memory contents: a fixed function of the address
    function automatic logic [7:0] memv(input logic [11:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd37;
        return m ^ {a[11:8], a[11:8]} ^ SALT;
    endfunction

    assign fetch_word = rom[pc[4:0]];
    assign dmem_rdata = memv(dmem_addr);

    function automatic logic [15:0] cmpw(input bit gt, input bit a, input logic [7:0] f);
        return {4'b0110, 1'b0, gt, 1'b0, a, f};
    endfunction

    function automatic bit is_two(input logic [15:0] w);
        return (w[15:12] == 4'hC) || (w[15:10] == 6'b111011);
    endfunction

    function automatic bit is_cmp(input logic [15:0] w);
        return (w[15:11] == 5'b01100) && !w[9];
    endfunction

    function automatic logic [11:0] ref_addr(input bit a, input logic [3:0] b, input logic [7:0] f);
        return a ? {b, f} : {{4{f[7]}}, f};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 32; i++) rom[i] = 16'h0000;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Entered at a negedge in Q1, leaves at the next Q1 negedge
    task automatic run_cycle(output logic [11:0] o_pc, output logic o_rd,
                             output logic [11:0] o_addr, output logic o_sq,
                             output logic o_skip);
        o_pc = pc;
        @(posedge clk); @(negedge clk);
        o_rd = dmem_rd; o_addr = dmem_addr; o_sq = slot_squashed;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        o_skip = skip_taken;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic exec_case(input string req, input bit gt, input bit a,
                             input logic [7:0] f, input logic [3:0] b,
                             input logic [7:0] w, input logic [15:0] follow);
        logic [11:0] opc, oaddr, ea;
        logic ord, osq, oskip, es, two;
        clear_rom();
        rom[0] = cmpw(gt, a, f);
        rom[1] = follow;
        rom[2] = 16'hF123;
        bank_sel = b; wreg = w;
        do_reset();
        ea  = ref_addr(a, b, f);
        es  = gt ? (memv(ea) > w) : (memv(ea) < w);
        two = is_two(follow);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk(req, "pc slot0", int'(opc), 0);
        chk(req, "read slot0", int'(ord), 1);
        chk(req, "addr slot0", int'(oaddr), int'(ea));
        chk(req, "skip slot0", int'(oskip), int'(es));
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R9", "squash slot1", int'(osq), int'(es));
        chk("R7", "read slot1", int'(ord), 0);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R10", "squash slot2", int'(osq), int'(es && two));
        chk("R8", "pc slot2", int'(opc), 2);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R9", "squash slot3", int'(osq), 0);
        chk("R8", "pc slot3", int'(opc), 3);
    endtask

    task automatic t_reset();
        clear_rom();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11", "pc in reset", int'(pc), 0);
        chk("R11", "phase in reset", int'(phase), 1);
        chk("R11", "read in reset", int'(dmem_rd), 0);
        chk("R11", "squash in reset", int'(slot_squashed), 0);
        chk("R11", "skip in reset", int'(skip_taken), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_phase();
        int exp_ph;
        clear_rom();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            exp_ph = 1 << (k % 4);
            chk("R6", "phase walk", int'(phase), exp_ph);
            chk("R8", "pc per phase", int'(pc), k / 4);
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic t_above_banked();
        logic [7:0] v;
        v = memv(12'h310);
        exec_case("R1 R4", 1'b1, 1'b1, 8'h10, 4'h3, v - 8'd1, 16'h0000);
        exec_case("R1 R4", 1'b1, 1'b1, 8'h10, 4'h3, v + 8'd1, 16'h0000);
        exec_case("R1 R4", 1'b1, 1'b1, 8'hE7, 4'hA, 8'h00, 16'h0000);
    endtask

    task automatic t_below_access();
        logic [7:0] v;
        v = memv(12'hF85);
        exec_case("R2 R5", 1'b0, 1'b0, 8'h85, 4'h2, v + 8'd1, 16'h0000);
        exec_case("R2 R5", 1'b0, 1'b0, 8'h85, 4'h2, v - 8'd1, 16'h0000);
        v = memv(12'h020);
        exec_case("R2 R5", 1'b0, 1'b0, 8'h20, 4'h7, v + 8'd1, 16'h0000);
        exec_case("R2 R5", 1'b0, 1'b0, 8'hFF, 4'h7, 8'hFF, 16'h0000);
    endtask

    task automatic t_equal();
        logic [7:0] v;
        v = memv(12'h544);
        exec_case("R3", 1'b1, 1'b1, 8'h44, 4'h5, v, 16'h0000);
        exec_case("R3", 1'b0, 1'b1, 8'h44, 4'h5, v, 16'h0000);
    endtask

    task automatic t_one_word();
        logic [7:0] v;
        v = memv(12'h310);
        exec_case("R9", 1'b1, 1'b1, 8'h10, 4'h3, v - 8'd1, 16'hE000);
        exec_case("R9", 1'b0, 1'b1, 8'h10, 4'h3, v + 8'd1, 16'hB0C4);
    endtask

    task automatic t_two_word();
        logic [7:0] v;
        v = memv(12'h310);
        exec_case("R10", 1'b1, 1'b1, 8'h10, 4'h3, v - 8'd1, 16'hC123);
        exec_case("R10", 1'b1, 1'b1, 8'h10, 4'h3, v - 8'd1, 16'hEE05);
        exec_case("R10", 1'b1, 1'b1, 8'h10, 4'h3, v - 8'd1, 16'hED00);
        exec_case("R10", 1'b0, 1'b1, 8'h10, 4'h3, v + 8'd1, 16'hEF10);
        exec_case("R10", 1'b1, 1'b1, 8'h10, 4'h3, v + 8'd1, 16'hC123);
    endtask

    task automatic t_squash_compare();
        logic [11:0] opc, oaddr;
        logic ord, osq, oskip;
        logic [7:0] v;
        v = memv(12'h310);
        clear_rom();
        rom[0] = cmpw(1'b1, 1'b1, 8'h10);
        rom[1] = cmpw(1'b1, 1'b1, 8'h10);
        rom[2] = cmpw(1'b1, 1'b1, 8'h10);
        bank_sel = 4'h3; wreg = v - 8'd1;
        do_reset();
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R12", "first compare skips", int'(oskip), 1);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R12", "dead compare squashed", int'(osq), 1);
        chk("R12", "dead compare read", int'(ord), 0);
        chk("R12", "dead compare skip", int'(oskip), 0);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R12", "third compare squash", int'(osq), 0);
        chk("R12", "third compare read", int'(ord), 1);
        chk("R12", "third compare skip", int'(oskip), 1);
        run_cycle(opc, ord, oaddr, osq, oskip);
        chk("R12", "after third squash", int'(osq), 1);
    endtask

    task automatic t_random(input int runs);
        logic [11:0] opc, oaddr;
        logic ord, osq, oskip, es, esq;
        logic [7:0] v;
        int st, sel;
        for (int r = 0; r < runs; r++) begin
            clear_rom();
            for (int i = 0; i < 20; i++) begin
                sel = $urandom % 5;
                case (sel)
                    0, 1:    rom[i] = cmpw(sel[0], 1'($urandom), 8'($urandom));
                    2:       rom[i] = {4'hC, 12'($urandom)};
                    3:       rom[i] = {6'b111011, 10'($urandom)};
                    default: rom[i] = 16'h0000;
                endcase
            end
            bank_sel = 4'($urandom);
            wreg     = 8'($urandom);
            do_reset();
            st = 0;
            for (int i = 0; i < 20; i++) begin
                run_cycle(opc, ord, oaddr, osq, oskip);
                esq = (st != 0);
                es  = 1'b0;
                if (st == 1) begin
                    st = is_two(rom[i]) ? 2 : 0;
                end else if (st == 2) begin
                    st = 0;
                end else if (is_cmp(rom[i])) begin
                    v  = memv(ref_addr(rom[i][8], bank_sel, rom[i][7:0]));
                    es = rom[i][10] ? (v > wreg) : (v < wreg);
                    if (es) st = 1;
                end
                chk("R9 R10", "random squash", int'(osq), int'(esq));
                chk("R1 R2 R3 R5", "random skip", int'(oskip), int'(es));
            end
            chk("R8", "random final pc", int'(pc), 20);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_phase();
        t_above_banked();
        t_below_access();
        t_equal();
        t_one_word();
        t_two_word();
        t_squash_compare();
        t_random(12);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule